// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast reference clock into the two timing strobes a UART needs: a sample tick at the oversampling rate and a bit tick at the serial bit rate. The sample rate is the reference clock divided by a 16-bit integer divisor plus a fraction in sixteenths. The fraction is realized by lengthening some sample periods by one reference clock. An accumulator places those long periods evenly, so over sixteen periods the average period equals the programmed divisor.

Three write strobes share one byte-wide data input. Two of them load the low and high divisor bytes. The third loads a control byte. That byte holds the fractional nibble in bits 3:0 and the oversampling selection in bits 5:4. The control byte is accepted only while the enhanced-feature enable input is high. The oversampling selection sets how many sample ticks make one bit tick, which is 16, 8 or 4. Choosing 8 or 4 therefore raises the highest reachable bit rate two or four times. Both tick outputs are one reference clock wide.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor is 0, the fraction is 0 and the mode is 16 samples per bit, so neither tick is issued until a divisor is written.
- R2: With a fractional nibble of 0, sample ticks come exactly D reference clocks apart, where D = {high byte, low byte}.
- R3: With fractional nibble N, the first period after a reload is D clocks long. Period j (j >= 1) is D + floor(j*N/16) - floor((j-1)*N/16) clocks long, so it is either D or D+1.
- R4: Control bits 5:4 select the samples per bit: 00 gives 16, 01 gives 8, 10 gives 4, and 11 gives 16. A bit tick comes with every M-th sample tick, counted from the last reload.
- R5: A control byte write while the enhanced-feature enable is low is ignored. The fraction, the mode and the running counters all stay as they were.
- R6: While the divisor is 0, no sample tick and no bit tick is issued, whatever the fraction and mode.
- R7: A write to either divisor byte, or an accepted control write, restarts the period counter, the accumulator and the bit count. The first sample tick then appears exactly D clocks after the write edge, even if the write lands in the middle of a period.
- R8: A bit tick never appears without a sample tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Write data shared by the three write strobes |
| wr_div_lo | input | 1 | Load the low divisor byte |
| wr_div_hi | input | 1 | Load the high divisor byte |
| wr_frac | input | 1 | Load the control byte (fraction in 3:0, mode in 5:4) |
| ext_en | input | 1 | Enhanced-feature enable; must be high for a control write to take effect |
| sample_tick | output | 1 | One-cycle strobe at the oversampling rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |

## Verification
The hardest case to reach is the exact position of each lengthened period within the accumulator's sixteen-period cycle. A single wrong carry moves a tick by only one clock and leaves the average rate almost unchanged. The stimulus reloads the block so the accumulator starts from a known zero. It then times every sample tick against the period-by-period formula, using random fractions including 15 and divisors as small as 1. Further directed cases place reloads in the middle of a period and issue a gated control write that would otherwise change both the fraction and the mode.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // oversampling selection, bits 5:4 of the control byte
  typedef enum logic [1:0] {
    OS_X16  = 2'b00,
    OS_X8   = 2'b01,
    OS_X4   = 2'b10,
    OS_X16B = 2'b11
  } os_mode_e;

  localparam int unsigned MAX_OS = 16;

  function automatic int unsigned os_ratio(os_mode_e m);
    case (m)
      OS_X8:   os_ratio = 8;
      OS_X4:   os_ratio = 4;
      default: os_ratio = 16;
    endcase
  endfunction

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_div_lo,
  input  logic              wr_div_hi,
  input  logic              wr_frac,
  input  logic              ext_en,
  output logic [DIV_W-1:0]  div_o,
  output logic [FRAC_W-1:0] frac_o,
  output os_mode_e          mode_o,
  output logic              reload_o
);

  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  os_mode_e          mode_q, mode_d;
  logic              frac_ok;

  always_comb begin
    frac_ok = wr_frac && ext_en;
    lo_d    = wr_div_lo ? wr_data : lo_q;
    hi_d    = wr_div_hi ? wr_data : hi_q;
    frac_d  = frac_ok ? wr_data[FRAC_W-1:0] : frac_q;
    mode_d  = frac_ok ? os_mode_e'(wr_data[FRAC_W+1:FRAC_W]) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
      mode_q <= OS_X16;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      frac_q <= frac_d;
      mode_q <= mode_d;
    end
  end

  assign div_o    = {hi_q, lo_q};
  assign frac_o   = frac_q;
  assign mode_o   = mode_q;
  assign reload_o = wr_div_lo || wr_div_hi || frac_ok;

endmodule

// File: rtl/frac_baud_period.sv
module frac_baud_period #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [DIV_W-1:0]  div,
  input  logic [FRAC_W-1:0] frac,
  output logic              period_end,
  output logic [DIV_W-1:0]  cnt_o
);

  logic [DIV_W-1:0]  cnt_q, cnt_d, len_m1;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              long_q, long_d, running;
  logic [FRAC_W:0]   sum;

  always_comb begin
    running    = (div != '0);
    len_m1     = long_q ? div : div - DIV_W'(1);
    period_end = running && (cnt_q == len_m1);
    sum        = {1'b0, acc_q} + {1'b0, frac};
    cnt_d      = cnt_q;
    acc_d      = acc_q;
    long_d     = long_q;
    if (reload) begin
      cnt_d  = '0;
      acc_d  = '0;
      long_d = 1'b0;
    end else if (!running) begin
      cnt_d  = '0;
    end else if (period_end) begin
      cnt_d  = '0;
      acc_d  = sum[FRAC_W-1:0];
      long_d = sum[FRAC_W];
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      long_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      long_q <= long_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv
  import frac_baud_pkg::*;
#(
  parameter int unsigned OS_MAX = MAX_OS,
  localparam int CNT_W = $clog2(OS_MAX)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reload,
  input  logic     sample_end,
  input  os_mode_e mode,
  output logic     bit_end
);

  logic [CNT_W-1:0] scnt_q, scnt_d, ratio_m1;

  always_comb begin
    ratio_m1 = CNT_W'(os_ratio(mode) - 1);
    bit_end  = sample_end && (scnt_q == ratio_m1);
    scnt_d   = scnt_q;
    if (reload)          scnt_d = '0;
    else if (bit_end)    scnt_d = '0;
    else if (sample_end) scnt_d = scnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scnt_q <= '0;
    else        scnt_q <= scnt_d;
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_div_lo,
  input  logic              wr_div_hi,
  input  logic              wr_frac,
  input  logic              ext_en,
  output logic              sample_tick,
  output logic              bit_tick
);

  logic [DIV_W-1:0]  div_w, cnt_w;
  logic [FRAC_W-1:0] frac_w;
  os_mode_e          mode_w;
  logic              reload_w, per_end_w, bit_end_w;
  logic              stick_q, stick_d, btick_q, btick_d;

  frac_baud_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_div_lo(wr_div_lo), .wr_div_hi(wr_div_hi), .wr_frac(wr_frac),
    .ext_en(ext_en), .div_o(div_w), .frac_o(frac_w), .mode_o(mode_w),
    .reload_o(reload_w)
  );

  frac_baud_period #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst_n(rst_n), .reload(reload_w), .div(div_w),
    .frac(frac_w), .period_end(per_end_w), .cnt_o(cnt_w)
  );

  frac_baud_bitdiv u_bitdiv (
    .clk(clk), .rst_n(rst_n), .reload(reload_w),
    .sample_end(per_end_w), .mode(mode_w), .bit_end(bit_end_w)
  );

  always_comb begin
    stick_d = per_end_w && !reload_w;
    btick_d = bit_end_w && !reload_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stick_q <= 1'b0;
      btick_q <= 1'b0;
    end else begin
      stick_q <= stick_d;
      btick_q <= btick_d;
    end
  end

  assign sample_tick = stick_q;
  assign bit_tick    = btick_q;

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_div_lo,
  input logic              wr_div_hi,
  input logic              wr_frac,
  input logic              ext_en,
  input logic              sample_tick,
  input logic              bit_tick,
  input logic [DIV_W-1:0]  div,
  input logic [FRAC_W-1:0] frac,
  input os_mode_e          mode,
  input logic [DIV_W-1:0]  cnt
);

  AST_ZERO_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !sample_tick);  // R6

  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);  // R8

  AST_DIV_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div_lo || wr_div_hi) |=> (!sample_tick && !bit_tick));  // R7

  AST_FRAC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frac && !ext_en && !wr_div_lo && !wr_div_hi) |=> ($stable(frac) && $stable(mode)));  // R5

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0) |-> (cnt <= div));  // R3

endmodule

bind frac_baud_gen frac_baud_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_div_lo(wr_div_lo), .wr_div_hi(wr_div_hi),
  .wr_frac(wr_frac), .ext_en(ext_en), .sample_tick(sample_tick),
  .bit_tick(bit_tick), .div(div_w), .frac(frac_w), .mode(mode_w), .cnt(cnt_w)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wr_data;
  logic       wr_div_lo, wr_div_hi, wr_frac, ext_en;
  logic       sample_tick, bit_tick;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int t_rel = 0;
  int cur_n = 0;
  int cur_m = 16;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_div_lo(wr_div_lo),
    .wr_div_hi(wr_div_hi), .wr_frac(wr_frac), .ext_en(ext_en),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_len(int d, int n, int j);
    if (j == 0) return d;
    return d + (j * n) / 16 - ((j - 1) * n) / 16;
  endfunction

  function automatic int ratio_of(logic [1:0] sel);
    case (sel)
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 16;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // kind 0: low byte, 1: high byte, 2: control byte
  task automatic wr(int kind, logic [7:0] d, bit en);
    wr_data   = d;
    ext_en    = en;
    wr_div_lo = (kind == 0);
    wr_div_hi = (kind == 1);
    wr_frac   = (kind == 2);
    @(posedge clk);
    @(negedge clk);
    wr_div_lo = 1'b0;
    wr_div_hi = 1'b0;
    wr_frac   = 1'b0;
    if (kind != 2 || en) t_rel = cyc;
    if (kind == 2 && en) begin
      cur_n = int'(d[3:0]);
      cur_m = ratio_of(d[5:4]);
    end
  endtask

  task automatic config_all(int d, logic [7:0] fb, bit en);
    wr(0, 8'(d), 1'b1);
    wr(1, 8'(d >> 8), 1'b1);
    wr(2, fb, en);
  endtask

  task automatic measure(int d, int n, int m, int cnt, string tag);
    int prev = t_rel;
    for (int k = 1; k <= cnt; k++) begin
      int w = 0;
      do begin
        @(negedge clk);
        w++;
        if (!sample_tick && bit_tick) chk(1'b0, "R8", 1, 0);
      end while (!sample_tick && w < d + 4);
      if (!sample_tick) begin
        chk(1'b0, tag, w, exp_len(d, n, k - 1));
        return;
      end
      chk((cyc - prev) == exp_len(d, n, k - 1), (k == 1) ? "R7" : tag,
          cyc - prev, exp_len(d, n, k - 1));
      chk(int'(bit_tick) == int'((k % m) == 0), "R4", int'(bit_tick),
          int'((k % m) == 0));
      prev = cyc;
    end
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_data = '0; ext_en = 1'b0;
    wr_div_lo = 1'b0; wr_div_hi = 1'b0; wr_frac = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet(40, "R1");

    // plain integer divisor, default 16x
    config_all(5, 8'h00, 1'b1);
    measure(5, 0, 16, 34, "R2");

    // gated control write would select 4x with N=10: must be ignored
    config_all(7, 8'h2A, 1'b0);
    measure(7, 0, 16, 20, "R5");

    config_all(7, 8'h2A, 1'b1);
    measure(7, 10, 4, 24, "R3");
    config_all(7, 8'h33, 1'b1);
    measure(7, 3, 16, 33, "R4");
    config_all(7, 8'h1F, 1'b1);
    measure(7, 15, 8, 20, "R4");

    // high byte in use
    config_all(259, 8'h05, 1'b1);
    measure(259, 5, 16, 3, "R2");

    // smallest divisor with the largest fraction
    config_all(1, 8'h2F, 1'b1);
    measure(1, 15, 4, 40, "R3");

    // reload in the middle of a period
    config_all(20, 8'h00, 1'b1);
    repeat (13) @(negedge clk);
    wr(0, 8'd9, 1'b1);
    measure(9, 0, 16, 5, "R7");

    // zero divisor, also with a fraction set
    wr(0, 8'd0, 1'b1);
    quiet(60, "R6");
    wr(2, 8'h27, 1'b1);
    quiet(60, "R6");

    for (int it = 0; it < 25; it++) begin
      bit en = ($urandom % 4) != 0;
      int d = en ? 1 + int'($urandom % 24) : 2 + int'($urandom % 23);
      logic [7:0] fb = 8'($urandom);
      config_all(d, fb, en);
      measure(d, cur_n, cur_m, 36, en ? "R3" : "R5");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule